// File: doc/BRIEF.md
# Cascadable Dual 16-bit Capture Timer

The block holds two 16-bit free-running timer/capture units, called the lower unit and the upper unit. Each unit has a count enable, a prescaled count rate and two capture channels. Each capture channel has a level input, an edge-select field, a capture register and an interrupt pulse. Both units take their count rate from one shared free-running divider. The divider is used as a clock-enable tick, never as a derived clock.

An 8-bit option register belongs to the upper unit, and only its bit 0 is used: the cascade-select bit. When that bit is set, the upper unit stops using its own controls. Its count enable is ignored and it advances once each time the lower counter wraps. It clears when the lower unit is enabled, and it captures on the lower unit's capture events. As a result, `{hi_ccrN, lo_ccrN}` forms a 32-bit capture of one free-running 32-bit count. In this mode the lower unit's interrupts serve the pair, and the upper unit's interrupts stay low.

Top module: `cap_pair_timer`

## Requirements
- R1: The option register is 8 bits wide. A write stores only `opt_wdata[0]`, which is the cascade-select bit, and bits 7:1 always read 0. The new value is visible on `opt_rdata` in the cycle after the write. It takes effect on counting from the clock edge after it becomes visible.
- R2: In independent mode, a unit's counter loads 0000H on the edge where its enable is first seen high after being low. After that it adds one on every count tick while enabled, wrapping from FFFFH to 0000H. It holds its value while disabled.
- R3: The count-rate field k (3 bits, values 0 to 7) gives one tick every 2^k clocks. The ticks come from a 7-bit divider that counts up from 0 after reset. A unit ticks in every cycle where the low k bits of the divider are all ones.
- R4: Each capture channel has a 2-bit edge-select field: 00 no capture, 01 rising edge, 10 falling edge, 11 either edge. An edge is a difference between the input level now and the level sampled one clock earlier.
- R5: On a capture event, the capture register loads the value its counter holds after that same clock edge. The matching interrupt output is high for exactly that one following cycle, so during the pulse the capture register equals the counter.
- R6: When cascade-select is 1, the upper unit's own enable and count rate have no effect. The upper counter adds one only on a lower-counter wrap from FFFFH, and both counters load 0000H together when the lower enable rises.
- R7: When cascade-select is 1, each upper capture register loads on the lower unit's event for the same channel, at the same edge as the lower capture register. The 32-bit pair is coherent even when the event coincides with the lower wrap, so it shows the upper half after its increment.
- R8: When cascade-select is 1, the upper unit's capture inputs and edge fields have no effect, and its interrupt outputs stay low.
- R9: After reset, all counters, capture registers and the option register read 0, and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_we | input | 1 | Option register write strobe |
| opt_wdata | input | 8 | Option register write data (bit 0 = cascade select) |
| opt_rdata | output | 8 | Option register read value |
| lo_en | input | 1 | Lower unit count enable (also the pair's enable in cascade) |
| lo_cks | input | 3 | Lower unit count-rate select |
| lo_edge0 | input | 2 | Lower channel 0 edge select |
| lo_edge1 | input | 2 | Lower channel 1 edge select |
| lo_cap0 | input | 1 | Lower channel 0 capture input |
| lo_cap1 | input | 1 | Lower channel 1 capture input |
| hi_en | input | 1 | Upper unit count enable |
| hi_cks | input | 3 | Upper unit count-rate select |
| hi_edge0 | input | 2 | Upper channel 0 edge select |
| hi_edge1 | input | 2 | Upper channel 1 edge select |
| hi_cap0 | input | 1 | Upper channel 0 capture input |
| hi_cap1 | input | 1 | Upper channel 1 capture input |
| lo_cnt | output | 16 | Lower counter value |
| hi_cnt | output | 16 | Upper counter value |
| lo_ccr0 | output | 16 | Lower capture register 0 |
| lo_ccr1 | output | 16 | Lower capture register 1 |
| hi_ccr0 | output | 16 | Upper capture register 0 |
| hi_ccr1 | output | 16 | Upper capture register 1 |
| lo_irq0 | output | 1 | Lower channel 0 capture interrupt pulse |
| lo_irq1 | output | 1 | Lower channel 1 capture interrupt pulse |
| hi_irq0 | output | 1 | Upper channel 0 capture interrupt pulse |
| hi_irq1 | output | 1 | Upper channel 1 capture interrupt pulse |

## Verification
The hardest case to reach is a capture event landing on the same clock edge as the lower counter's wrap from FFFFH while cascaded. That is the one cycle where a torn 32-bit value could appear. The stimulus restarts the pair at the fastest count rate and waits out almost the full 65536-cycle lower period. It then sets channel 0 to either-edge capture and toggles its input on every cycle across the wrap, so that some event is certain to coincide with it. Meanwhile the upper unit's own enable and capture inputs are kept active, to show that they have no effect.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int EDGE_W = 2;

  typedef enum logic [EDGE_W-1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_t;

  // Event on one capture input given its mode, current and previous level.
  function automatic logic edge_hit(logic [EDGE_W-1:0] mode, logic cur, logic prev);
    unique case (edge_mode_t'(mode))
      EDGE_RISE: return cur & ~prev;
      EDGE_FALL: return ~cur & prev;
      EDGE_BOTH: return cur ^ prev;
      default:   return 1'b0;
    endcase
  endfunction

  // Divider tap: tick when the low `sel` bits of the divider are all ones.
  function automatic logic tick_hit(logic [31:0] div, logic [31:0] sel);
    logic [31:0] mask;
    mask = (32'd1 << sel) - 32'd1;
    return (div & mask) == mask;
  endfunction
endpackage

// File: rtl/cpt_prescaler.sv
module cpt_prescaler #(
  parameter int SEL_W = 3,
  parameter int N     = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N-1:0][SEL_W-1:0]   sel,
  output logic [N-1:0]              tick
);
  import cpt_pkg::*;
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_tap
    assign tick[i] = tick_hit(32'(div_q), 32'(sel[i]));
  end
endmodule

// File: rtl/cpt_edge.sv
module cpt_edge #(
  parameter int N = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [N-1:0]                    lvl,
  input  logic [N-1:0][cpt_pkg::EDGE_W-1:0] mode,
  output logic [N-1:0]                    ev
);
  import cpt_pkg::*;

  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_ch
    assign ev[i] = edge_hit(mode[i], lvl[i], lvl_q[i]);

    // R4: with no edge selected a channel never raises an event
    a_r4_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i] == EDGE_NONE) |-> !ev[i]);
  end
endmodule

// File: rtl/cpt_unit.sv
module cpt_unit #(
  parameter int W  = 16,
  parameter int CH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic [CH-1:0] ev,
  input  logic          irq_en,
  output logic [W-1:0]  cnt,
  output logic [W-1:0]  ccr [CH],
  output logic [CH-1:0] irq
);
  logic [W-1:0] cnt_nxt;

  always_comb begin
    if (start)     cnt_nxt = '0;
    else if (step) cnt_nxt = cnt + 1'b1;
    else           cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  for (genvar c = 0; c < CH; c++) begin : g_cap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ccr[c] <= '0;
        irq[c] <= 1'b0;
      end else begin
        if (ev[c]) ccr[c] <= cnt_nxt;
        irq[c] <= ev[c] & irq_en;
      end
    end

    // R5: while the interrupt pulses, the capture register shows the counter
    a_r5_irq_shows_value: assert property (@(posedge clk) disable iff (!rst_n)
      irq[c] |-> (ccr[c] == cnt));
  end

  // R2: without start or step the counter keeps its value
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !step) |=> $stable(cnt));
endmodule

// File: rtl/cap_pair_timer.sv
module cap_pair_timer #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 3,
  parameter int OPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opt_we,
  input  logic [OPT_W-1:0] opt_wdata,
  output logic [OPT_W-1:0] opt_rdata,
  input  logic             lo_en,
  input  logic [SEL_W-1:0] lo_cks,
  input  logic [1:0]       lo_edge0,
  input  logic [1:0]       lo_edge1,
  input  logic             lo_cap0,
  input  logic             lo_cap1,
  input  logic             hi_en,
  input  logic [SEL_W-1:0] hi_cks,
  input  logic [1:0]       hi_edge0,
  input  logic [1:0]       hi_edge1,
  input  logic             hi_cap0,
  input  logic             hi_cap1,
  output logic [CNT_W-1:0] lo_cnt,
  output logic [CNT_W-1:0] hi_cnt,
  output logic [CNT_W-1:0] lo_ccr0,
  output logic [CNT_W-1:0] lo_ccr1,
  output logic [CNT_W-1:0] hi_ccr0,
  output logic [CNT_W-1:0] hi_ccr1,
  output logic             lo_irq0,
  output logic             lo_irq1,
  output logic             hi_irq0,
  output logic             hi_irq1
);
  localparam int CH = 2;

  // option register: only the cascade-select bit is stored
  logic cse;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cse <= 1'b0;
    else if (opt_we) cse <= opt_wdata[0];
  end
  assign opt_rdata = {{(OPT_W-1){1'b0}}, cse};

  // shared count-rate divider
  logic [1:0] tick;
  cpt_prescaler #(.SEL_W(SEL_W), .N(2)) u_div (
    .clk(clk), .rst_n(rst_n), .sel({hi_cks, lo_cks}), .tick(tick));

  // capture edge detection for each unit
  logic [CH-1:0] lo_ev, hi_ev_own;
  cpt_edge #(.N(CH)) u_lo_edge (
    .clk(clk), .rst_n(rst_n), .lvl({lo_cap1, lo_cap0}),
    .mode({lo_edge1, lo_edge0}), .ev(lo_ev));
  cpt_edge #(.N(CH)) u_hi_edge (
    .clk(clk), .rst_n(rst_n), .lvl({hi_cap1, hi_cap0}),
    .mode({hi_edge1, hi_edge0}), .ev(hi_ev_own));

  // enable tracking
  logic lo_en_q, hi_eff_q, hi_eff;
  assign hi_eff = hi_en & ~cse;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_en_q  <= 1'b0;
      hi_eff_q <= 1'b0;
    end else begin
      lo_en_q  <= lo_en;
      hi_eff_q <= hi_eff;
    end
  end

  // named internal events
  logic lo_start, lo_step, lo_wrap;
  logic hi_start, hi_step, hi_irq_en;
  logic [CH-1:0] hi_ev;
  assign lo_start  = lo_en & ~lo_en_q;
  assign lo_step   = lo_en & tick[0] & ~lo_start;
  assign lo_wrap   = lo_step & (lo_cnt == {CNT_W{1'b1}});
  assign hi_start  = cse ? lo_start : (hi_eff & ~hi_eff_q);
  assign hi_step   = cse ? lo_wrap  : (hi_eff & tick[1]);
  assign hi_ev     = cse ? lo_ev    : hi_ev_own;
  assign hi_irq_en = ~cse;

  logic [CNT_W-1:0] lo_ccr [CH];
  logic [CNT_W-1:0] hi_ccr [CH];
  logic [CH-1:0]    lo_irq, hi_irq;

  cpt_unit #(.W(CNT_W), .CH(CH)) u_lo (
    .clk(clk), .rst_n(rst_n), .start(lo_start), .step(lo_step), .ev(lo_ev),
    .irq_en(1'b1), .cnt(lo_cnt), .ccr(lo_ccr), .irq(lo_irq));
  cpt_unit #(.W(CNT_W), .CH(CH)) u_hi (
    .clk(clk), .rst_n(rst_n), .start(hi_start), .step(hi_step), .ev(hi_ev),
    .irq_en(hi_irq_en), .cnt(hi_cnt), .ccr(hi_ccr), .irq(hi_irq));

  assign lo_ccr0 = lo_ccr[0];
  assign lo_ccr1 = lo_ccr[1];
  assign hi_ccr0 = hi_ccr[0];
  assign hi_ccr1 = hi_ccr[1];
  assign {lo_irq1, lo_irq0} = lo_irq;
  assign {hi_irq1, hi_irq0} = hi_irq;

  // R1: a write is visible, reduced to bit 0, on the next cycle
  a_r1_opt_write: assert property (@(posedge clk) disable iff (!rst_n)
    opt_we |=> (opt_rdata == {{(OPT_W-1){1'b0}}, $past(opt_wdata[0])}));

  // R6: cascaded upper half moves only on a lower wrap or a pair restart
  a_r6_slave_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cse && !lo_wrap && !lo_start) |=> $stable(hi_cnt));

  // R7: a lower channel-0 event in cascade leaves upper capture equal to upper count
  a_r7_pair_coherent: assert property (@(posedge clk) disable iff (!rst_n)
    (cse && lo_ev[0]) |=> (hi_ccr0 == hi_cnt && lo_ccr0 == lo_cnt));

  // R8: cascaded upper unit raises no interrupt
  a_r8_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cse |=> (!hi_irq0 && !hi_irq1));
endmodule

// File: tb/cap_pair_timer_tb.sv
module cap_pair_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       opt_we = 1'b0;
  logic [7:0] opt_wdata = '0;
  logic [7:0] opt_rdata;
  logic       lo_en = 1'b0, hi_en = 1'b0;
  logic [2:0] lo_cks = '0, hi_cks = '0;
  logic [1:0] lo_edge0 = '0, lo_edge1 = '0, hi_edge0 = '0, hi_edge1 = '0;
  logic       lo_cap0 = 1'b0, lo_cap1 = 1'b0, hi_cap0 = 1'b0, hi_cap1 = 1'b0;
  logic [15:0] lo_cnt, hi_cnt, lo_ccr0, lo_ccr1, hi_ccr0, hi_ccr1;
  logic       lo_irq0, lo_irq1, hi_irq0, hi_irq1;

  cap_pair_timer u_dut (
    .clk(clk), .rst_n(rst_n), .opt_we(opt_we), .opt_wdata(opt_wdata), .opt_rdata(opt_rdata),
    .lo_en(lo_en), .lo_cks(lo_cks), .lo_edge0(lo_edge0), .lo_edge1(lo_edge1),
    .lo_cap0(lo_cap0), .lo_cap1(lo_cap1),
    .hi_en(hi_en), .hi_cks(hi_cks), .hi_edge0(hi_edge0), .hi_edge1(hi_edge1),
    .hi_cap0(hi_cap0), .hi_cap1(hi_cap1),
    .lo_cnt(lo_cnt), .hi_cnt(hi_cnt), .lo_ccr0(lo_ccr0), .lo_ccr1(lo_ccr1),
    .hi_ccr0(hi_ccr0), .hi_ccr1(hi_ccr1),
    .lo_irq0(lo_irq0), .lo_irq1(lo_irq1), .hi_irq0(hi_irq0), .hi_irq1(hi_irq1));

  int checks = 0, fails = 0;
  bit finished = 0;

  // ---------------- reference model ----------------
  int m_div, m_opt, m_lo, m_hi;
  int m_lc [2], m_hc [2];
  bit m_li [2], m_hq [2];
  bit m_lo_en_p, m_hi_eff_p;
  bit m_lin_p [2], m_hin_p [2];

  function automatic bit ev_of(int mode, bit cur, bit prev);
    if (mode == 1) return cur && !prev;
    if (mode == 2) return !cur && prev;
    if (mode == 3) return cur != prev;
    return 0;
  endfunction

  function automatic bit tick_of(int div, int k);
    return (div % (1 << k)) == ((1 << k) - 1);
  endfunction

  task automatic model_reset();
    m_div = 0; m_opt = 0; m_lo = 0; m_hi = 0;
    m_lo_en_p = 0; m_hi_eff_p = 0;
    for (int i = 0; i < 2; i++) begin
      m_lc[i] = 0; m_hc[i] = 0; m_li[i] = 0; m_hq[i] = 0;
      m_lin_p[i] = 0; m_hin_p[i] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit casc, ls, hs, heff, lt, ht;
      bit lev [2], hev [2], lcur [2], hcur [2];
      int nlo, nhi, v32;
      casc = m_opt[0];
      lt = tick_of(m_div, int'(lo_cks));
      ht = tick_of(m_div, int'(hi_cks));
      lcur[0] = lo_cap0; lcur[1] = lo_cap1; hcur[0] = hi_cap0; hcur[1] = hi_cap1;
      lev[0] = ev_of(int'(lo_edge0), lcur[0], m_lin_p[0]);
      lev[1] = ev_of(int'(lo_edge1), lcur[1], m_lin_p[1]);
      hev[0] = ev_of(int'(hi_edge0), hcur[0], m_hin_p[0]);
      hev[1] = ev_of(int'(hi_edge1), hcur[1], m_hin_p[1]);
      ls = lo_en && !m_lo_en_p;
      heff = hi_en && !casc;
      hs = heff && !m_hi_eff_p;
      if (casc) begin
        // treat the pair as one 32-bit count
        v32 = m_hi * 65536 + m_lo;
        if (ls) v32 = 0;
        else if (lo_en && lt) v32 = v32 + 1;
        nlo = v32 % 65536;
        nhi = (v32 / 65536) % 65536;
        if (v32 < 0) begin nlo = v32 & 16'hFFFF; nhi = (v32 >>> 16) & 16'hFFFF; end
      end else begin
        nlo = ls ? 0 : (lo_en && lt) ? (m_lo + 1) % 65536 : m_lo;
        nhi = hs ? 0 : (heff && ht) ? (m_hi + 1) % 65536 : m_hi;
      end
      for (int i = 0; i < 2; i++) begin
        if (lev[i]) m_lc[i] = nlo;
        m_li[i] = lev[i];
        if (casc ? lev[i] : hev[i]) m_hc[i] = nhi;
        m_hq[i] = !casc && hev[i];
        m_lin_p[i] = lcur[i];
        m_hin_p[i] = hcur[i];
      end
      m_lo = nlo; m_hi = nhi;
      m_lo_en_p = lo_en; m_hi_eff_p = heff;
      m_div = (m_div + 1) % 128;
      if (opt_we) m_opt = opt_wdata[0];
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      if (fails < 20)
        $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // compare on every falling edge, away from the active edge
  always @(negedge clk) if (!finished) begin
    chk("R1 opt_rdata", int'(opt_rdata), m_opt);
    chk("R2/R3/R6 lo_cnt", int'(lo_cnt), m_lo);
    chk("R2/R3/R6 hi_cnt", int'(hi_cnt), m_hi);
    chk("R4/R5 lo_ccr0", int'(lo_ccr0), m_lc[0]);
    chk("R4/R5 lo_ccr1", int'(lo_ccr1), m_lc[1]);
    chk("R7 hi_ccr0", int'(hi_ccr0), m_hc[0]);
    chk("R7 hi_ccr1", int'(hi_ccr1), m_hc[1]);
    chk("R5 lo_irq0", int'(lo_irq0), int'(m_li[0]));
    chk("R5 lo_irq1", int'(lo_irq1), int'(m_li[1]));
    chk("R8 hi_irq0", int'(hi_irq0), int'(m_hq[0]));
    chk("R8 hi_irq1", int'(hi_irq1), int'(m_hq[1]));
  end

  // ---------------- stimulus ----------------
  logic [15:0] lf = 16'hACE1;

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic wiggle(int n, bit lo_on, bit hi_on);
    repeat (n) begin
      @(negedge clk); #2;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      if (lo_on) begin lo_cap0 = lf[0]; lo_cap1 = lf[3]; end
      if (hi_on) begin hi_cap0 = lf[5]; hi_cap1 = lf[9]; end
    end
  endtask

  task automatic wr_opt(logic [7:0] d);
    @(negedge clk); #2; opt_we = 1'b1; opt_wdata = d;
    @(negedge clk); #2; opt_we = 1'b0;
  endtask

  initial begin
    idle(3);
    // R9: reset state checked by the per-cycle compare while rst_n is low
    chk("R9 reset lo_cnt", int'(lo_cnt), 0);
    chk("R9 reset opt", int'(opt_rdata), 0);
    rst_n = 1'b1;
    idle(2);

    // R1: reserved bits read zero, bit 0 kept
    wr_opt(8'hFF);
    chk("R1 write FF", int'(opt_rdata), 1);
    wr_opt(8'hFE);
    chk("R1 write FE", int'(opt_rdata), 0);

    // R2/R3/R4/R5: independent mode, mixed rates and edge modes
    lo_cks = 3'd0; hi_cks = 3'd3;
    lo_edge0 = 2'b01; lo_edge1 = 2'b10; hi_edge0 = 2'b11; hi_edge1 = 2'b00;
    lo_en = 1'b1; hi_en = 1'b1;
    wiggle(300, 1, 1);
    lo_cks = 3'd7; hi_cks = 3'd5;
    lo_edge0 = 2'b11; lo_edge1 = 2'b00; hi_edge0 = 2'b10; hi_edge1 = 2'b01;
    wiggle(600, 1, 1);
    // R2: hold while disabled, restart from zero on re-enable
    lo_en = 1'b0;
    wiggle(100, 1, 1);
    lo_en = 1'b1; lo_cks = 3'd0;
    hi_cks = 3'd1;
    // R2: independent lower wrap at the fastest rate
    wiggle(66000, 1, 1);

    // R6/R7/R8: cascade; upper enable and inputs kept busy but ignored
    wr_opt(8'h01);
    lo_en = 1'b0; idle(3);
    hi_en = 1'b1; hi_edge0 = 2'b11; hi_edge1 = 2'b11;
    lo_edge0 = 2'b00; lo_edge1 = 2'b01;
    lo_en = 1'b1;
    wiggle(65520, 0, 1);
    // R7: capture events on every cycle across the lower wrap
    lo_edge0 = 2'b11;
    repeat (30) begin
      @(negedge clk); #2;
      lo_cap0 = ~lo_cap0; lo_cap1 = ~lo_cap1;
      hi_cap0 = ~hi_cap0;
    end
    chk("R6 upper after wrap", int'(hi_cnt), 1);
    chk("R7 pair coherent", int'(hi_ccr0), int'(hi_cnt));
    // R6: prescaled cascade
    lo_cks = 3'd2;
    wiggle(400, 1, 1);

    // R1/R2: leave cascade, upper restarts on its own enable
    wr_opt(8'h00);
    wiggle(300, 1, 1);
    idle(2);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog (R1..R9 run) actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule